// File: doc/BRIEF.md
# 100 Mb/s Receive Code-Group Decoder

This block sits after code-group alignment in a 100 Mb/s receive path. It takes one aligned 5-bit code group per clock and drives the media-independent receive signals: a data nibble, a data-valid flag, an error flag and carrier sense. A frame may only open with the two-symbol start delimiter (J then K) after line idle. Both delimiter symbols come out as the preamble nibble 0101. Data symbols are mapped back to their nibbles. The two-symbol end delimiter (T then R) closes the frame.

A small sequence tracker watches the delimiter order. Any delimiter symbol seen out of place raises the error flag. Inside a frame, an invalid, unassigned or transmit-error symbol also raises it. Line idle inside a frame aborts the frame. Every output is registered, so the response to a code group appears one clock after that group is sampled.

Top module: `pcs_rx_decoder`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `rxd_o`, `rx_dv_o`, `rx_er_o` and `crs_o` are all low. The tracker starts out not having seen idle.
- R2: A J group (11000) that directly follows an idle group (11111), outside a frame, gives `crs_o`=1, `rx_dv_o`=1, `rx_er_o`=0 and `rxd_o`=0101 one clock later. Carrier sense only rises in this way.
- R3: A J group anywhere else raises `rx_er_o`. This covers J after reset before any idle, J after the end delimiter without idle in between, and J inside a frame.
- R4: A K group (10001) directly after the start J gives `rxd_o`=0101 with `rx_dv_o` and `crs_o` high and no error. Any other group after the start J raises `rx_er_o` and drops `rx_dv_o` and `crs_o`.
- R5: A K group in any other position raises `rx_er_o`.
- R6: Inside a frame, data groups decode as follows, with `rx_dv_o`=`crs_o`=1 and `rx_er_o`=0: 11110→0, 01001→1, 10100→2, 10101→3, 01010→4, 01011→5, 01110→6, 01111→7, 10010→8, 10011→9, 10110→A, 10111→B, 11010→C, 11011→D, 11100→E, 11101→F.
- R7: A T group (01101) in a frame gives `rx_dv_o`=0 with `crs_o`=1. If an R group (00111) follows at once, `crs_o` falls with no error. Data-valid only falls without an error on T.
- R8: If T is followed by anything other than R, `rx_er_o` is raised and `crs_o` and `rx_dv_o` are low.
- R9: An R group that does not directly follow the closing T raises `rx_er_o`. So does a T group received outside a frame.
- R10: While `rx_dv_o` is high, the invalid groups 00000, 00001, 00110 and 11001 raise `rx_er_o`. So do the unassigned groups 00010, 00011, 00101, 01000, 01100 and 10000. Inside a frame the frame continues, with `rxd_o`=0000.
- R11: An H group (00100) received while `rx_dv_o` is high raises `rx_er_o` for that nibble.
- R12: An idle group received while `rx_dv_o` is high drops `rx_dv_o` and `crs_o` and pulses `rx_er_o` for one clock. That idle also counts as line idle for a following J.
- R13: Outside a frame, data, invalid, unassigned and H groups raise no error and leave all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Code-group clock, one group per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| group_i | input | 5 | Aligned received code group |
| rxd_o | output | 4 | Decoded receive nibble |
| rx_dv_o | output | 1 | Receive data valid |
| rx_er_o | output | 1 | Receive error |
| crs_o | output | 1 | Carrier sense |

## Verification
The bench drives each of the 32 code groups into four positions: line idle, right after the start J, mid-frame, and right after the closing T. A decoder that ignored context would accept a stray J, K or R, and this sweep exposes it. So would one that took a lone J as a start of frame, or closed a frame on T alone. A wrong table entry or a missing unassigned code shows up as a wrong nibble or a missing error. Two further sequences check a J that arrives with no idle before it: one straight after reset and one straight after the end delimiter. A design that opened a frame there would raise carrier instead of the error flag. A mid-frame idle must abort the frame with a single error pulse, and a following J must then open a new frame.

// File: rtl/pcs_rx_dec_pkg.sv
package pcs_rx_dec_pkg;
  localparam int GRP_W = 5;
  localparam int NIB_W = 4;

  localparam logic [GRP_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [GRP_W-1:0] CG_J    = 5'b11000;
  localparam logic [GRP_W-1:0] CG_K    = 5'b10001;
  localparam logic [GRP_W-1:0] CG_T    = 5'b01101;
  localparam logic [GRP_W-1:0] CG_R    = 5'b00111;
  localparam logic [GRP_W-1:0] CG_H    = 5'b00100;

  localparam logic [NIB_W-1:0] PRE_NIB = 4'b0101;

  typedef enum logic [2:0] {
    GK_DATA, GK_IDLE, GK_J, GK_K, GK_T, GK_R, GK_HALT, GK_BAD
  } grp_kind_e;

  typedef enum logic [2:0] {
    ST_HUNT, ST_IDLE, ST_GOT_J, ST_FRAME, ST_GOT_T
  } rx_state_e;

  typedef struct packed {
    logic [NIB_W-1:0] rxd;
    logic             dv;
    logic             er;
    logic             crs;
  } mii_rx_t;
endpackage

// File: rtl/pcs_rx_group_classify.sv
module pcs_rx_group_classify
  import pcs_rx_dec_pkg::*;
(
  input  logic [GRP_W-1:0] group_i,
  output grp_kind_e        kind_o,
  output logic [NIB_W-1:0] nib_o
);
  always_comb begin
    kind_o = GK_DATA;
    nib_o  = '0;
    unique case (group_i)
      5'b11110: nib_o = 4'h0;
      5'b01001: nib_o = 4'h1;
      5'b10100: nib_o = 4'h2;
      5'b10101: nib_o = 4'h3;
      5'b01010: nib_o = 4'h4;
      5'b01011: nib_o = 4'h5;
      5'b01110: nib_o = 4'h6;
      5'b01111: nib_o = 4'h7;
      5'b10010: nib_o = 4'h8;
      5'b10011: nib_o = 4'h9;
      5'b10110: nib_o = 4'hA;
      5'b10111: nib_o = 4'hB;
      5'b11010: nib_o = 4'hC;
      5'b11011: nib_o = 4'hD;
      5'b11100: nib_o = 4'hE;
      5'b11101: nib_o = 4'hF;
      CG_IDLE:  kind_o = GK_IDLE;
      CG_J:     kind_o = GK_J;
      CG_K:     kind_o = GK_K;
      CG_T:     kind_o = GK_T;
      CG_R:     kind_o = GK_R;
      CG_H:     kind_o = GK_HALT;
      default:  kind_o = GK_BAD;
    endcase
  end
endmodule

// File: rtl/pcs_rx_frame_fsm.sv
module pcs_rx_frame_fsm
  import pcs_rx_dec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  grp_kind_e        kind_i,
  input  logic [NIB_W-1:0] nib_i,
  output mii_rx_t          nxt_o
);
  rx_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    nxt_o   = '0;
    unique case (state_q)
      ST_HUNT: begin
        if (kind_i == GK_IDLE) state_d = ST_IDLE;
        else if (kind_i inside {GK_J, GK_K, GK_T, GK_R}) nxt_o.er = 1'b1;
      end
      ST_IDLE: begin
        if (kind_i == GK_J) begin
          state_d   = ST_GOT_J;
          nxt_o.rxd = PRE_NIB;
          nxt_o.dv  = 1'b1;
          nxt_o.crs = 1'b1;
        end else if (kind_i inside {GK_K, GK_T, GK_R}) begin
          state_d  = ST_HUNT;
          nxt_o.er = 1'b1;
        end else if (kind_i != GK_IDLE) begin
          state_d = ST_HUNT;
        end
      end
      ST_GOT_J: begin
        if (kind_i == GK_K) begin
          state_d   = ST_FRAME;
          nxt_o.rxd = PRE_NIB;
          nxt_o.dv  = 1'b1;
          nxt_o.crs = 1'b1;
        end else begin
          state_d  = (kind_i == GK_IDLE) ? ST_IDLE : ST_HUNT;
          nxt_o.er = 1'b1;
        end
      end
      ST_FRAME: begin
        if (kind_i == GK_DATA) begin
          nxt_o.rxd = nib_i;
          nxt_o.dv  = 1'b1;
          nxt_o.crs = 1'b1;
        end else if (kind_i == GK_T) begin
          state_d   = ST_GOT_T;
          nxt_o.crs = 1'b1;
        end else if (kind_i == GK_IDLE) begin
          state_d  = ST_IDLE;
          nxt_o.er = 1'b1;
        end else begin
          nxt_o.dv  = 1'b1;
          nxt_o.crs = 1'b1;
          nxt_o.er  = 1'b1;
        end
      end
      ST_GOT_T: begin
        if (kind_i == GK_R) begin
          state_d = ST_HUNT;
        end else begin
          state_d  = (kind_i == GK_IDLE) ? ST_IDLE : ST_HUNT;
          nxt_o.er = 1'b1;
        end
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_HUNT;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/pcs_rx_out_reg.sv
module pcs_rx_out_reg
  import pcs_rx_dec_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  mii_rx_t d_i,
  output mii_rx_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/pcs_rx_decoder.sv
module pcs_rx_decoder
  import pcs_rx_dec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [GRP_W-1:0] group_i,
  output logic [NIB_W-1:0] rxd_o,
  output logic             rx_dv_o,
  output logic             rx_er_o,
  output logic             crs_o
);
  grp_kind_e        kind;
  logic [NIB_W-1:0] nib;
  mii_rx_t          nxt, cur;

  pcs_rx_group_classify u_classify (
    .group_i (group_i),
    .kind_o  (kind),
    .nib_o   (nib)
  );

  pcs_rx_frame_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .kind_i (kind),
    .nib_i  (nib),
    .nxt_o  (nxt)
  );

  pcs_rx_out_reg u_oreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (nxt),
    .q_o    (cur)
  );

  assign rxd_o   = cur.rxd;
  assign rx_dv_o = cur.dv;
  assign rx_er_o = cur.er;
  assign crs_o   = cur.crs;
endmodule

// File: rtl/pcs_rx_decoder_chk.sv
module pcs_rx_decoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [4:0] group_i,
  input logic [3:0] rxd_o,
  input logic       rx_dv_o,
  input logic       rx_er_o,
  input logic       crs_o
);
  function automatic logic bad_code(input logic [4:0] c);
    return c inside {5'b00000, 5'b00001, 5'b00110, 5'b11001, 5'b00010,
                     5'b00011, 5'b00101, 5'b01000, 5'b01100, 5'b10000};
  endfunction

  assert_crs_rise_on_j_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(crs_o) |-> ($past(group_i) == 5'b11000) && rx_dv_o && (rxd_o == 4'b0101));

  assert_clean_dv_fall_on_t_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rx_dv_o) && !rx_er_o) |-> ($past(group_i) == 5'b01101) && crs_o);

  assert_clean_crs_fall_on_r_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(crs_o) && !rx_er_o) |-> ($past(group_i) == 5'b00111));

  assert_bad_in_frame_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_dv_o && bad_code(group_i)) |=> rx_er_o);

  assert_halt_in_frame_flags_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_dv_o && group_i == 5'b00100) |=> rx_er_o);

  assert_idle_abort_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_dv_o && group_i == 5'b11111) |=> rx_er_o && !rx_dv_o && !crs_o);
endmodule

bind pcs_rx_decoder pcs_rx_decoder_chk u_chk (.*);

// File: tb/pcs_rx_decoder_bench.sv
module pcs_rx_decoder_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] group_i = 5'b11111;
  logic [3:0] rxd_o;
  logic       rx_dv_o, rx_er_o, crs_o;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [4:0] I = 5'b11111, J = 5'b11000, K = 5'b10001,
                         T = 5'b01101, R = 5'b00111, H = 5'b00100;

  always #10 clk_i = ~clk_i;

  pcs_rx_decoder u_pcs_rx_decoder (.*);

  function automatic logic [4:0] enc(input int n);
    case (n)
      0: return 5'b11110;  1: return 5'b01001;  2: return 5'b10100;  3: return 5'b10101;
      4: return 5'b01010;  5: return 5'b01011;  6: return 5'b01110;  7: return 5'b01111;
      8: return 5'b10010;  9: return 5'b10011; 10: return 5'b10110; 11: return 5'b10111;
      12: return 5'b11010; 13: return 5'b11011; 14: return 5'b11100; default: return 5'b11101;
    endcase
  endfunction

  // returns nibble index, or -1 when the group is not data
  function automatic int data_nib(input logic [4:0] c);
    for (int n = 0; n < 16; n++) if (enc(n) == c) return n;
    return -1;
  endfunction

  task automatic check(input string req, input logic dv, input logic crs,
                       input logic er, input logic [3:0] rxd, input logic [4:0] g);
    checks++;
    if ({rx_dv_o, crs_o, rx_er_o, rxd_o} !== {dv, crs, er, rxd}) begin
      failures++;
      $display("FAIL %s grp=%b actual dv=%b crs=%b er=%b rxd=%h expected dv=%b crs=%b er=%b rxd=%h",
               req, g, rx_dv_o, crs_o, rx_er_o, rxd_o, dv, crs, er, rxd);
    end
  endtask

  task automatic push(input logic [4:0] g);
    group_i = g;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic pushc(input logic [4:0] g, input string req, input logic dv,
                       input logic crs, input logic er, input logic [3:0] rxd);
    push(g);
    check(req, dv, crs, er, rxd, g);
  endtask

  initial begin
    #5;
    check("R1", 0, 0, 0, 4'h0, group_i);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    check("R1", 0, 0, 0, 4'h0, group_i);
    // J before any idle after reset
    pushc(J, "R3", 0, 0, 1, 4'h0);
    push(I); push(I);

    // Sweep A: every group in line idle
    for (int c = 0; c < 32; c++) begin
      logic [4:0] g = c[4:0];
      push(I); push(I);
      if (g == J) begin
        pushc(g, "R2", 1, 1, 0, 4'h5);
        push(K); push(T); push(R);
      end else if (g == K) pushc(g, "R5", 0, 0, 1, 4'h0);
      else if (g == T || g == R) pushc(g, "R9", 0, 0, 1, 4'h0);
      else pushc(g, "R13", 0, 0, 0, 4'h0);
    end

    // Sweep B: every group right after the start J
    for (int c = 0; c < 32; c++) begin
      logic [4:0] g = c[4:0];
      push(I); push(I);
      pushc(J, "R2", 1, 1, 0, 4'h5);
      if (g == K) begin
        pushc(g, "R4", 1, 1, 0, 4'h5);
        push(T); push(R);
      end else pushc(g, "R4", 0, 0, 1, 4'h0);
    end

    // Sweep C: every group inside a frame
    for (int c = 0; c < 32; c++) begin
      logic [4:0] g = c[4:0];
      int n = data_nib(g);
      push(I); push(I); push(J);
      pushc(K, "R4", 1, 1, 0, 4'h5);
      push(enc(c % 16));
      if (n >= 0) pushc(g, "R6", 1, 1, 0, n[3:0]);
      else if (g == I) pushc(g, "R12", 0, 0, 1, 4'h0);
      else if (g == T) pushc(g, "R7", 0, 1, 0, 4'h0);
      else if (g == J) pushc(g, "R3", 1, 1, 1, 4'h0);
      else if (g == K) pushc(g, "R5", 1, 1, 1, 4'h0);
      else if (g == R) pushc(g, "R9", 1, 1, 1, 4'h0);
      else if (g == H) pushc(g, "R11", 1, 1, 1, 4'h0);
      else pushc(g, "R10", 1, 1, 1, 4'h0);
      if (g == I) begin
        // the abort idle counts as line idle: a J opens a new frame
        pushc(J, "R12", 1, 1, 0, 4'h5);
        push(K); push(T); push(R);
      end else if (g == T) begin
        pushc(R, "R7", 0, 0, 0, 4'h0);
      end else begin
        pushc(T, "R7", 0, 1, 0, 4'h0);
        pushc(R, "R7", 0, 0, 0, 4'h0);
      end
    end

    // Sweep D: every group after the closing T
    for (int c = 0; c < 32; c++) begin
      logic [4:0] g = c[4:0];
      push(I); push(I); push(J); push(K); push(enc(3));
      pushc(T, "R7", 0, 1, 0, 4'h0);
      if (g == R) pushc(g, "R7", 0, 0, 0, 4'h0);
      else pushc(g, "R8", 0, 0, 1, 4'h0);
    end

    // J straight after the end delimiter, with no idle between
    push(I); push(I); push(J); push(K); push(T); push(R);
    pushc(J, "R3", 0, 0, 1, 4'h0);
    push(I);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule